// File: doc/BRIEF.md
# Parallel NOR Sector Erase Sequencer

This block erases a contiguous range of sectors in a 16-bit parallel NOR flash that accepts the JEDEC-style unlock command set. A single start pulse supplies a signed first and last sector index. A flat vector gives the byte base address of every sector, and a mask marks the sectors that are protected. The block then drives a simple synchronous memory bus until the job is finished. It ends by pulsing `done` with a 3-bit status code.

It checks the arguments and the protect mask before it issues any bus cycle. It then works through the sectors in ascending order. For each sector it writes the six-word unlock/setup/confirm sequence, polls the sector base until bit 7 reads as 1, and writes the read-array command. A per-sector cycle budget guards the polling. A run that touched the flash waits a fixed settle interval before it reports.

Top module: `nor_erase_seq`

## Requirements
- R1: A start whose first index is negative, whose first index is above the last, or whose last index is not below NSECT ends with status 1 (invalid). No bus read or write occurs.
- R2: If any sector in the first..last range has its protect mask bit set, the run ends with status 2 (protected). No write occurs.
- R3: Each sector gets six writes in consecutive cycles: 0xAA to FLASH_BASE+0xAAA, 0x55 to FLASH_BASE+0x554, 0x80 to FLASH_BASE+0xAAA, 0xAA to FLASH_BASE+0xAAA, 0x55 to FLASH_BASE+0x554, and finally 0x30 to the sector's base address. The 0xAAA and 0x554 offsets are word addresses 0x555 and 0x2AA shifted left by one.
- R4: After the 0x30 write, the block reads the sector base every second cycle. Read data arrives in the cycle after `memRe`. The sector is complete on the first returned word whose bit 7 is 1.
- R5: After each completed sector, the block writes 0xF0 to FLASH_BASE+0xAAA. Sectors are handled in strictly ascending index order.
- R6: A cycle counter starts at 0 on the first command write of each sector. A poll check taken while the counter exceeds TMO_LIMIT ends the run with status 3 (timeout). It then writes 0xF0 to FLASH_BASE+0xAAA and erases no further sector. A timeout takes precedence over a ready bit seen in the same check. So the k-th poll completes only if 5+2k <= TMO_LIMIT.
- R7: On the completion path and the timeout path, `done` rises exactly SETTLE_CYC+1 cycles after the final 0xF0 write.
- R8: `done` is low after reset and is high for exactly one cycle per run. `status` is valid in that cycle, and a fully erased range reports 0 (ok).
- R9: A start pulse that arrives while a run is in progress has no effect.
- R10: `memWe` and `memRe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| firstIdx | input | IDX_W (signed) | First sector of the range |
| lastIdx | input | IDX_W (signed) | Last sector of the range |
| sectBases | input | NSECT*ADDR_W | Byte base address of sector i at bits [i*ADDR_W +: ADDR_W] |
| protMask | input | NSECT | Bit i set means sector i is protected |
| memAddr | output | ADDR_W | Bus byte address |
| memWdata | output | 16 | Bus write data |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memRdata | input | 16 | Read data, valid the cycle after memRe |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 invalid, 2 protected, 3 timeout |

## Verification
Two events can land on the same poll check: the timeout budget running out and the flash reporting bit 7 set. The bench's flash model raises bit 7 on a chosen read count for each sector. That count is swept across the boundary where the poll check's cycle count passes TMO_LIMIT, so on one side completion wins and on the other the ready word shows up in the very check where the budget is exceeded. A case is judged by its status code, by the exact write list (one 0xF0 and then no further sector), and by the settle gap to `done`.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
  localparam int DATA_W = 16;
  localparam int WORD_A = 'h555;
  localparam int WORD_B = 'h2AA;

  localparam logic [DATA_W-1:0] CMD_UNLK1 = 16'h00AA;
  localparam logic [DATA_W-1:0] CMD_UNLK2 = 16'h0055;
  localparam logic [DATA_W-1:0] CMD_SETUP = 16'h0080;
  localparam logic [DATA_W-1:0] CMD_GO    = 16'h0030;
  localparam logic [DATA_W-1:0] CMD_ARRAY = 16'h00F0;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_INVALID   = 3'd1,
    ST_PROTECTED = 3'd2,
    ST_TIMEOUT   = 3'd3
  } status_e;

  typedef struct packed {
    logic    load;
    logic    sectNext;
    logic    sectRewind;
    logic    stepClr;
    logic    stepNext;
    logic    tmrClr;
    logic    settleClr;
    logic    wrCmd;
    logic    rdPoll;
    logic    wrReset;
    logic    setStatus;
    status_e statusVal;
  } ctl_t;
endpackage

// File: rtl/nor_erase_dp.sv
module nor_erase_dp
  import nor_erase_pkg::*;
#(
  parameter int NSECT = 11,
  parameter int ADDR_W = 24,
  parameter int IDX_W = 5,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter int TMO_LIMIT = 1000,
  parameter int SETTLE_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic signed [IDX_W-1:0] firstIdx,
  input  logic signed [IDX_W-1:0] lastIdx,
  input  logic [NSECT*ADDR_W-1:0] sectBases,
  input  logic [NSECT-1:0]        protMask,
  input  logic [DATA_W-1:0]       memRdata,
  output logic                    argBad,
  output logic                    curProt,
  output logic                    atLast,
  output logic                    stepLast,
  output logic                    tmoHit,
  output logic                    pollReady,
  output logic                    settleEnd,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    memWe,
  output logic                    memRe,
  output logic [2:0]              status
);
  localparam int SIDX_W = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int TMR_W  = $clog2(TMO_LIMIT + 2) + 1;
  localparam int SC_W   = $clog2(SETTLE_CYC + 1);
  localparam logic [ADDR_W-1:0] UNLK_A = FLASH_BASE + ADDR_W'(WORD_A << 1);
  localparam logic [ADDR_W-1:0] UNLK_B = FLASH_BASE + ADDR_W'(WORD_B << 1);

  logic [SIDX_W-1:0] cur, firstR, lastR;
  logic [2:0]        step;
  logic [TMR_W-1:0]  tmr;
  logic [SC_W-1:0]   sCnt;
  logic [ADDR_W-1:0] curBase;
  logic              rdUnused;

  assign argBad = (int'(firstIdx) < 0) || (int'(firstIdx) > int'(lastIdx)) ||
                  (int'(lastIdx) >= NSECT);
  assign curBase   = sectBases[cur*ADDR_W +: ADDR_W];
  assign curProt   = protMask[cur];
  assign atLast    = (cur == lastR);
  assign stepLast  = (step == 3'd5);
  assign tmoHit    = (tmr > TMR_W'(TMO_LIMIT));
  assign pollReady = memRdata[7];
  assign rdUnused  = ^{memRdata[DATA_W-1:8], memRdata[6:0]};
  assign settleEnd = (sCnt == SC_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur    <= '0;
      firstR <= '0;
      lastR  <= '0;
      step   <= '0;
      tmr    <= '0;
      sCnt   <= '0;
      status <= ST_OK;
    end else begin
      if (ctl.load) begin
        cur    <= firstIdx[SIDX_W-1:0];
        firstR <= firstIdx[SIDX_W-1:0];
        lastR  <= lastIdx[SIDX_W-1:0];
      end else if (ctl.sectRewind) begin
        cur <= firstR;
      end else if (ctl.sectNext) begin
        cur <= cur + 1'b1;
      end
      if (ctl.stepClr)       step <= '0;
      else if (ctl.stepNext) step <= step + 1'b1;
      if (ctl.tmrClr)        tmr <= '0;
      else if (tmr != '1)    tmr <= tmr + 1'b1;
      if (ctl.settleClr)     sCnt <= '0;
      else if (!settleEnd)   sCnt <= sCnt + 1'b1;
      if (ctl.setStatus)     status <= ctl.statusVal;
    end
  end

  always_comb begin
    memAddr  = curBase;
    memWdata = '0;
    memWe    = 1'b0;
    memRe    = 1'b0;
    if (ctl.wrCmd) begin
      memWe = 1'b1;
      unique case (step)
        3'd0:    begin memAddr = UNLK_A; memWdata = CMD_UNLK1; end
        3'd1:    begin memAddr = UNLK_B; memWdata = CMD_UNLK2; end
        3'd2:    begin memAddr = UNLK_A; memWdata = CMD_SETUP; end
        3'd3:    begin memAddr = UNLK_A; memWdata = CMD_UNLK1; end
        3'd4:    begin memAddr = UNLK_B; memWdata = CMD_UNLK2; end
        default: begin memAddr = curBase; memWdata = CMD_GO; end
      endcase
    end else if (ctl.wrReset) begin
      memWe    = 1'b1;
      memAddr  = UNLK_A;
      memWdata = CMD_ARRAY;
    end else if (ctl.rdPoll) begin
      memRe = 1'b1;
    end
  end
endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
  import nor_erase_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic argBad,
  input  logic curProt,
  input  logic atLast,
  input  logic stepLast,
  input  logic tmoHit,
  input  logic pollReady,
  input  logic settleEnd,
  output ctl_t ctl,
  output logic done
);
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_CMD, S_POLL_RD, S_POLL_CHK,
    S_TMO_WR, S_RST_WR, S_SETTLE, S_DONE
  } state_e;

  state_e state, stateNx;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNx;
  end

  assign done = (state == S_DONE);

  always_comb begin
    stateNx = state;
    ctl = '0;
    ctl.statusVal = ST_OK;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        if (argBad) begin
          ctl.setStatus = 1'b1;
          ctl.statusVal = ST_INVALID;
          stateNx = S_DONE;
        end else begin
          stateNx = S_SCAN;
        end
      end
      S_SCAN: begin
        if (curProt) begin
          ctl.setStatus = 1'b1;
          ctl.statusVal = ST_PROTECTED;
          stateNx = S_DONE;
        end else if (atLast) begin
          ctl.sectRewind = 1'b1;
          ctl.tmrClr = 1'b1;
          ctl.stepClr = 1'b1;
          stateNx = S_CMD;
        end else begin
          ctl.sectNext = 1'b1;
        end
      end
      S_CMD: begin
        ctl.wrCmd = 1'b1;
        ctl.stepNext = 1'b1;
        if (stepLast) stateNx = S_POLL_RD;
      end
      S_POLL_RD: begin
        ctl.rdPoll = 1'b1;
        stateNx = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (tmoHit)         stateNx = S_TMO_WR;
        else if (pollReady) stateNx = S_RST_WR;
        else                stateNx = S_POLL_RD;
      end
      S_TMO_WR: begin
        ctl.wrReset = 1'b1;
        ctl.setStatus = 1'b1;
        ctl.statusVal = ST_TIMEOUT;
        ctl.settleClr = 1'b1;
        stateNx = S_SETTLE;
      end
      S_RST_WR: begin
        ctl.wrReset = 1'b1;
        if (atLast) begin
          ctl.setStatus = 1'b1;
          ctl.statusVal = ST_OK;
          ctl.settleClr = 1'b1;
          stateNx = S_SETTLE;
        end else begin
          ctl.sectNext = 1'b1;
          ctl.tmrClr = 1'b1;
          ctl.stepClr = 1'b1;
          stateNx = S_CMD;
        end
      end
      S_SETTLE: if (settleEnd) stateNx = S_DONE;
      S_DONE:   stateNx = S_IDLE;
      default:  stateNx = S_IDLE;
    endcase
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int NSECT = 11,
  parameter int ADDR_W = 24,
  parameter int IDX_W = $clog2(NSECT) + 1,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter int TMO_LIMIT = 1000,
  parameter int SETTLE_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic signed [IDX_W-1:0] firstIdx,
  input  logic signed [IDX_W-1:0] lastIdx,
  input  logic [NSECT*ADDR_W-1:0] sectBases,
  input  logic [NSECT-1:0]        protMask,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [15:0]             memWdata,
  output logic                    memWe,
  output logic                    memRe,
  input  logic [15:0]             memRdata,
  output logic                    done,
  output logic [2:0]              status
);
  ctl_t ctl;
  logic argBad, curProt, atLast, stepLast, tmoHit, pollReady, settleEnd;

  nor_erase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .argBad(argBad),
    .curProt(curProt), .atLast(atLast), .stepLast(stepLast),
    .tmoHit(tmoHit), .pollReady(pollReady), .settleEnd(settleEnd),
    .ctl(ctl), .done(done)
  );

  nor_erase_dp #(
    .NSECT(NSECT), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .FLASH_BASE(FLASH_BASE),
    .TMO_LIMIT(TMO_LIMIT), .SETTLE_CYC(SETTLE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .firstIdx(firstIdx),
    .lastIdx(lastIdx), .sectBases(sectBases), .protMask(protMask),
    .memRdata(memRdata), .argBad(argBad), .curProt(curProt),
    .atLast(atLast), .stepLast(stepLast), .tmoHit(tmoHit),
    .pollReady(pollReady), .settleEnd(settleEnd), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .memRe(memRe), .status(status)
  );
endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic [2:0]  status,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] memWdata
);
  logic wroteAny;

  always_ff @(posedge clk) begin
    if (!rstN)      wroteAny <= 1'b0;
    else if (done)  wroteAny <= 1'b0;
    else if (memWe) wroteAny <= 1'b1;
  end

  // R10
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  confirm_then_poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memWdata == 16'h0030) |=> memRe);

  // R4
  poll_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> (!memRe && !memWe));

  // R1 R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && (status == 3'd1 || status == 3'd2)) |-> !wroteAny);
endmodule

bind nor_erase_seq nor_erase_chk u_chk (
  .clk(clk), .rstN(rstN), .done(done), .status(status),
  .memWe(memWe), .memRe(memRe), .memWdata(memWdata)
);

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb;
  localparam int NS = 6;
  localparam int AW = 20;
  localparam int IW = $clog2(NS) + 1;
  localparam int LIM = 20;
  localparam int SET = 3;
  localparam int SSZ = 'h4000;
  localparam logic [AW-1:0] FB = 20'h40000;
  localparam int UA = 'h40AAA;
  localparam int UB = 'h40554;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [IW-1:0] firstIdx = '0;
  logic signed [IW-1:0] lastIdx = '0;
  logic [NS*AW-1:0] sectBases;
  logic [NS-1:0] protMask = '0;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic memWe, memRe, done;
  logic [2:0] status;

  always #5 clk = ~clk;

  nor_erase_seq #(.NSECT(NS), .ADDR_W(AW), .IDX_W(IW), .FLASH_BASE(FB),
                  .TMO_LIMIT(LIM), .SETTLE_CYC(SET)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .firstIdx(firstIdx),
    .lastIdx(lastIdx), .sectBases(sectBases), .protMask(protMask),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .done(done), .status(status)
  );

  for (genvar g = 0; g < NS; g++) begin : g_base
    assign sectBases[g*AW +: AW] = FB + AW'(g * SSZ);
  end

  int checks = 0, fails = 0;
  int cyc = 0, wrN = 0, rdN = 0, rdBad = 0, doneCnt = 0, doneLong = 0;
  int lastWrCyc = 0, doneCyc = 0, rdCnt = 0, actSect = 0;
  int readyAt [NS];
  int wrA [0:255];
  int wrD [0:255];
  logic prevDone = 1'b0;

  // flash model and bus monitor
  always @(posedge clk) begin
    cyc++;
    if (memWe) begin
      if (wrN < 256) begin wrA[wrN] = int'(memAddr); wrD[wrN] = int'(memWdata); end
      wrN++;
      lastWrCyc = cyc;
      if (memWdata == 16'h0030) begin
        rdCnt = 0;
        actSect = (int'(memAddr) - int'(FB)) / SSZ;
      end
    end
    if (memRe) begin
      rdN++;
      if (int'(memAddr) != int'(FB) + actSect * SSZ) rdBad++;
      rdCnt++;
      memRdata <= (rdCnt >= readyAt[actSect]) ? 16'h0080 : 16'hFF7F;
    end
    if (done) begin
      doneCnt++;
      doneCyc = cyc;
      if (prevDone) doneLong++;
    end
    prevDone = done;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input int f, input int l, input logic [NS-1:0] p, input int poke);
    int expA [0:127];
    int expD [0:127];
    int expN = 0, expSt = 0, d0, mis = 0, w0;
    bit inv, hit = 0;
    string tag;
    inv = (f < 0) || (f > l) || (l >= NS);
    if (inv) expSt = 1;
    else begin
      for (int s = f; s <= l; s++) if (p[s]) hit = 1;
      if (hit) expSt = 2;
      else begin
        for (int s = f; s <= l; s++) begin
          expA[expN] = UA; expD[expN] = 'hAA; expN++;
          expA[expN] = UB; expD[expN] = 'h55; expN++;
          expA[expN] = UA; expD[expN] = 'h80; expN++;
          expA[expN] = UA; expD[expN] = 'hAA; expN++;
          expA[expN] = UB; expD[expN] = 'h55; expN++;
          expA[expN] = int'(FB) + s * SSZ; expD[expN] = 'h30; expN++;
          expA[expN] = UA; expD[expN] = 'hF0; expN++;
          if (5 + 2 * readyAt[s] > LIM) begin expSt = 3; break; end
        end
      end
    end
    tag = (expSt == 1) ? "R1" : (expSt == 2) ? "R2" : (expSt == 3) ? "R6" : "R8";
    @(negedge clk);
    wrN = 0; rdN = 0; rdBad = 0; d0 = doneCnt;
    protMask = p; firstIdx = IW'(f); lastIdx = IW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && doneCnt == d0; i++) begin
      if (poke > 0 && i == poke) begin start = 1'b1; firstIdx = IW'(NS - 1); lastIdx = IW'(NS - 1); end
      if (poke > 0 && i == poke + 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    check(doneCnt == d0 + 1 && doneLong == 0, "R8 single done pulse", doneCnt - d0, 1);
    check(int'(status) == expSt, tag, int'(status), expSt);
    check(wrN == expN, (expSt == 0) ? "R3 write count" : tag, wrN, expN);
    for (int k = 0; k < expN && k < wrN; k++)
      if (wrA[k] != expA[k] || wrD[k] != expD[k]) mis++;
    if (expN > 0) begin
      check(mis == 0, "R3 R5 write sequence", mis, 0);
      check(rdBad == 0, "R4 poll address", rdBad, 0);
      check(doneCyc - lastWrCyc == SET + 1, "R7 settle gap", doneCyc - lastWrCyc, SET + 1);
    end else begin
      check(rdN == 0, tag, rdN, 0);
    end
    if (poke > 0) begin
      w0 = wrN;
      repeat (80) @(negedge clk);
      check(doneCnt == d0 + 1 && wrN == w0, "R9 start while busy", doneCnt - d0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) readyAt[s] = 1;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && memWe == 1'b0 && memRe == 1'b0, "R8 reset state", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 R3 R5 R7: sweep every range including illegal ones
    for (int f = -1; f <= NS; f++)
      for (int l = -1; l <= NS; l++)
        runOp(f, l, '0, 0);
    // R2: one protected sector, ranges covering and avoiding it
    for (int p = 0; p < NS; p++) begin
      runOp(0, NS - 1, NS'(1) << p, 0);
      runOp(p, p, NS'(1) << p, 0);
      if (p > 0) runOp(0, p - 1, NS'(1) << p, 0);
    end
    // R4 R6: ready read count across the timeout boundary
    for (int k = 1; k <= 10; k++) begin
      readyAt[2] = k;
      runOp(2, 2, '0, 0);
    end
    // R6: timeout in the middle of a range stops later sectors
    readyAt[1] = 4; readyAt[2] = 1; readyAt[3] = 9;
    runOp(1, 5, '0, 0);
    readyAt[3] = 7;
    runOp(0, 5, '0, 0);
    // R9: start pulse during a run
    for (int s = 0; s < NS; s++) readyAt[s] = 3;
    runOp(0, 2, '0, 10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule